// File: doc/BRIEF.md
# Packet Slice Transfer Sequencer

This block moves one packet between an on-chip FIFO and an external device over a chip-select region, with no processor involvement. Software gives a packet length in bytes, a direction (transmit: FIFO to device; receive: device to FIFO) and a 4-bit slice-size code, then pulses start. The sequencer cuts the packet into consecutive slices of the selected size. It hands each slice to a bus cycle engine over a request/done handshake, and the engine performs the actual external bus cycles.

The external bus is shared with direct processor accesses. A slice that has been issued runs to completion without interruption. A processor request that arrives during a slice is granted only after that slice ends. Between slices, a waiting processor request wins over starting the next slice. Only one packet is in flight at a time, so the path is half-duplex. A start pulse received while a packet is active is refused, and the active packet is not affected.

Top module: `pkt_slice_seq`

## Requirements
- R1: Slice-size codes 0 to 9 select 1, 2, 4, 8, 16, 24, 32, 40, 48 and 56 bytes in that order. Every slice except the last carries exactly the selected size.
- R2: A start with a code of 10 to 15, or with a packet length of 0, sets `cfg_err` in the next cycle. It leaves `busy` low and issues no slice. The next accepted start clears `cfg_err`.
- R3: `slc_burst` is high for a packet whose selected slice size is above 4 bytes and low otherwise.
- R4: The slices of a packet cover the packet length exactly. There are ceil(length/size) slices, and the last slice carries the remaining bytes.
- R5: A start while `busy` is high is refused. `start_rej` pulses in the next cycle, and the active packet keeps its direction (`slc_dir`: 0 transmit, 1 receive), length and slice size.
- R6: A transmit slice is issued only when `tx_level` is at least the slice's byte count. A receive slice is issued only when `rx_space` is at least the slice's byte count.
- R7: `slc_req` stays high, with `slc_bytes` stable, until the cycle in which `slc_done` is sampled high. `slc_done` has no effect while no slice is requested.
- R8: `cpu_grant` is never high while a slice is requested. A processor request waiting between slices is granted before the next slice is issued. The grant is held until `cpu_req` drops.
- R9: When the last slice's `slc_done` is sampled, `done` and `irq` go high for exactly one cycle and `busy` falls in the same cycle.
- R10: After reset, `busy`, `done`, `irq`, `cfg_err`, `start_rej`, `slc_req` and `cpu_grant` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start pulse for a new packet |
| cfg_dir | input | 1 | Packet direction, 0 transmit, 1 receive |
| cfg_code | input | 4 | Slice-size code |
| cfg_size | input | SIZE_W | Packet length in bytes |
| start_rej | output | 1 | One-cycle pulse: start refused while busy |
| cfg_err | output | 1 | Last start had an invalid code or zero length |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle pulse at packet completion |
| irq | output | 1 | One-cycle interrupt pulse at packet completion |
| tx_level | input | LVL_W | Bytes available in the transmit FIFO |
| rx_space | input | LVL_W | Free bytes in the receive FIFO |
| slc_req | output | 1 | Slice request to the bus cycle engine |
| slc_dir | output | 1 | Direction of the current packet |
| slc_burst | output | 1 | Slices of this packet use burst cycles |
| slc_bytes | output | 6 | Byte count of the requested slice |
| slc_done | input | 1 | Bus cycle engine finished the slice |
| cpu_req | input | 1 | Processor wants the external bus |
| cpu_grant | output | 1 | Processor owns the external bus |

## Verification
The assertions assume that the bus cycle engine answers each request with `slc_done` only while `slc_req` is high. They also assume that the processor keeps `cpu_req` high until it has been granted, and that the FIFO level inputs change only between clock edges. The stimulus respects these assumptions. It raises `slc_done` only after it has seen a request, after a random delay of zero to three cycles. It drops a processor request only once the grant is visible, and it drives random FIFO levels that often fall short of a slice, which forces stalls. Directed cases add deliberate stray `slc_done` pulses and starved FIFOs, which exercise the inputs the block must ignore.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int CODE_W    = 4;
  localparam int SLC_W     = 6;
  localparam int NUM_CODES = 10;

  typedef enum logic [1:0] {ST_ARB, ST_GRANT, ST_SLICE} arb_st_t;

  // codes 0..3 are powers of two, 4..9 step by 8 bytes from 16
  function automatic logic [SLC_W-1:0] code_bytes(input logic [CODE_W-1:0] c);
    logic [SLC_W-1:0] r;
    case (c)
      CODE_W'(0): r = SLC_W'(1);
      CODE_W'(1): r = SLC_W'(2);
      CODE_W'(2): r = SLC_W'(4);
      CODE_W'(3): r = SLC_W'(8);
      default:    r = (c < CODE_W'(NUM_CODES)) ? SLC_W'({c - CODE_W'(2), 3'b000}) : '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pss_bpt_decode.sv
module pss_bpt_decode
  import pss_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SLC_W-1:0]  bytes,
  output logic              valid,
  output logic              burst
);
  assign valid = (code < CODE_W'(NUM_CODES));
  assign bytes = code_bytes(code);
  assign burst = valid && (bytes > SLC_W'(4));
endmodule

// File: rtl/pss_pkt_tracker.sv
module pss_pkt_tracker
  import pss_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic              cfg_dir,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [SLC_W-1:0]  dec_bytes,
  input  logic              dec_valid,
  input  logic              dec_burst,
  input  logic              slice_fin,
  output logic              busy,
  output logic              pkt_dir,
  output logic              pkt_burst,
  output logic [SLC_W-1:0]  cur_slice,
  output logic              done,
  output logic              irq,
  output logic              cfg_err,
  output logic              start_rej
);
  logic [SIZE_W-1:0] remain;
  logic [SLC_W-1:0]  bpt_q;

  assign cur_slice = (remain < SIZE_W'(bpt_q)) ? remain[SLC_W-1:0] : bpt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pkt_dir   <= 1'b0;
      pkt_burst <= 1'b0;
      remain    <= '0;
      bpt_q     <= '0;
      done      <= 1'b0;
      irq       <= 1'b0;
      cfg_err   <= 1'b0;
      start_rej <= 1'b0;
    end else begin
      done      <= 1'b0;
      irq       <= 1'b0;
      start_rej <= 1'b0;
      if (cfg_start) begin
        if (busy) begin
          start_rej <= 1'b1;
        end else if (!dec_valid || cfg_size == '0) begin
          cfg_err <= 1'b1;
        end else begin
          busy      <= 1'b1;
          remain    <= cfg_size;
          bpt_q     <= dec_bytes;
          pkt_dir   <= cfg_dir;
          pkt_burst <= dec_burst;
          cfg_err   <= 1'b0;
        end
      end
      if (slice_fin && busy) begin
        remain <= remain - SIZE_W'(cur_slice);
        if (remain == SIZE_W'(cur_slice)) begin
          busy <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> !busy && $past(busy));
  p_reject_r5: assert property (@(posedge clk) disable iff (rst) cfg_start && busy |=> start_rej);
  p_bad_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_start && !busy && !dec_valid |=> cfg_err && !busy);
  p_remain_live_r4: assert property (@(posedge clk) disable iff (rst) busy |-> remain != '0);
  p_dir_held_r5: assert property (@(posedge clk) disable iff (rst) busy && $past(busy) |-> $stable(pkt_dir));
endmodule

// File: rtl/pss_bus_arb.sv
module pss_bus_arb
  import pss_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             pkt_dir,
  input  logic [SLC_W-1:0] cur_slice,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_space,
  input  logic             cpu_req,
  input  logic             slc_done,
  output logic             slc_req,
  output logic [SLC_W-1:0] slc_bytes,
  output logic             cpu_grant,
  output logic             slice_fin
);
  arb_st_t st;
  logic    room;

  assign room      = pkt_dir ? (rx_space >= LVL_W'(cur_slice)) : (tx_level >= LVL_W'(cur_slice));
  assign slc_req   = (st == ST_SLICE);
  assign cpu_grant = (st == ST_GRANT);
  assign slice_fin = (st == ST_SLICE) && slc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ARB;
      slc_bytes <= '0;
    end else begin
      case (st)
        ST_ARB: begin
          if (cpu_req) begin
            st <= ST_GRANT;
          end else if (busy && room) begin
            st        <= ST_SLICE;
            slc_bytes <= cur_slice;
          end
        end
        ST_GRANT: if (!cpu_req) st <= ST_ARB;
        ST_SLICE: if (slc_done) st <= ST_ARB;
        default:  st <= ST_ARB;
      endcase
    end
  end

  p_slice_hold_r7: assert property (@(posedge clk) disable iff (rst)
    slc_req && !slc_done |=> slc_req && $stable(slc_bytes));
  p_no_grant_mid_slice_r8: assert property (@(posedge clk) disable iff (rst)
    slc_req && !slc_done |=> !cpu_grant);
  p_cpu_first_r8: assert property (@(posedge clk) disable iff (rst)
    !slc_req && !cpu_grant && cpu_req |=> !slc_req);
  p_grant_held_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_grant && cpu_req |=> cpu_grant);
  p_tx_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(slc_req) && !pkt_dir |-> $past(tx_level) >= LVL_W'(slc_bytes));
  p_rx_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(slc_req) && pkt_dir |-> $past(rx_space) >= LVL_W'(slc_bytes));
  p_slice_in_pkt_r4: assert property (@(posedge clk) disable iff (rst)
    slc_req |-> busy && slc_bytes != '0);
endmodule

// File: rtl/pkt_slice_seq.sv
module pkt_slice_seq
  import pss_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int LVL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic              cfg_dir,
  input  logic [3:0]        cfg_code,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic              start_rej,
  output logic              cfg_err,
  output logic              busy,
  output logic              done,
  output logic              irq,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_space,
  output logic              slc_req,
  output logic              slc_dir,
  output logic              slc_burst,
  output logic [5:0]        slc_bytes,
  input  logic              slc_done,
  input  logic              cpu_req,
  output logic              cpu_grant
);
  logic [SLC_W-1:0] dec_bytes;
  logic             dec_valid;
  logic             dec_burst;
  logic [SLC_W-1:0] cur_slice;
  logic             slice_fin;

  pss_bpt_decode u_dec (
    .code  (cfg_code),
    .bytes (dec_bytes),
    .valid (dec_valid),
    .burst (dec_burst)
  );

  pss_pkt_tracker #(.SIZE_W(SIZE_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .cfg_start (cfg_start),
    .cfg_dir   (cfg_dir),
    .cfg_size  (cfg_size),
    .dec_bytes (dec_bytes),
    .dec_valid (dec_valid),
    .dec_burst (dec_burst),
    .slice_fin (slice_fin),
    .busy      (busy),
    .pkt_dir   (slc_dir),
    .pkt_burst (slc_burst),
    .cur_slice (cur_slice),
    .done      (done),
    .irq       (irq),
    .cfg_err   (cfg_err),
    .start_rej (start_rej)
  );

  pss_bus_arb #(.LVL_W(LVL_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .pkt_dir   (slc_dir),
    .cur_slice (cur_slice),
    .tx_level  (tx_level),
    .rx_space  (rx_space),
    .cpu_req   (cpu_req),
    .slc_done  (slc_done),
    .slc_req   (slc_req),
    .slc_bytes (slc_bytes),
    .cpu_grant (cpu_grant),
    .slice_fin (slice_fin)
  );
endmodule

// File: tb/sim_pkt_slice_seq.sv
module sim_pkt_slice_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W = 16;
  localparam int LVL_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_start = 1'b0, cfg_dir = 1'b0;
  logic [3:0] cfg_code = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic start_rej, cfg_err, busy, done, irq;
  logic [LVL_W-1:0] tx_level = 7'd64, rx_space = 7'd64;
  logic slc_req, slc_dir, slc_burst;
  logic [5:0] slc_bytes;
  logic slc_done = 1'b0, cpu_req = 1'b0;
  logic cpu_grant;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_slice_seq #(.SIZE_W(SIZE_W), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_dir(cfg_dir), .cfg_code(cfg_code),
    .cfg_size(cfg_size), .start_rej(start_rej), .cfg_err(cfg_err), .busy(busy), .done(done),
    .irq(irq), .tx_level(tx_level), .rx_space(rx_space), .slc_req(slc_req), .slc_dir(slc_dir),
    .slc_burst(slc_burst), .slc_bytes(slc_bytes), .slc_done(slc_done), .cpu_req(cpu_req),
    .cpu_grant(cpu_grant)
  );

  function automatic int bpt_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16 + (code - 4) * 8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_packet(input int size, input int code, input bit dir,
                            input bit rnd_lvl, input bit rnd_cpu, input bit do_rej);
    int bpt, rem, expn, nslc, total, cnt, cyc, exp_b, prev_tx, prev_rx;
    bit prev_req, finished, last_fired, rej_wait, rej_sent;
    bpt = bpt_of(code); rem = size; expn = (size + bpt - 1) / bpt;
    nslc = 0; total = 0; cnt = 0; cyc = 0; prev_req = 0; finished = 0;
    last_fired = 0; rej_wait = 0; rej_sent = 0;
    cfg_start = 1; cfg_code = 4'(code); cfg_dir = dir; cfg_size = SIZE_W'(size);
    @(negedge clk);
    cfg_start = 0;
    chk(busy == 1, "R5 start accepted when idle", busy, 1);
    chk(cfg_err == 0, "R2 error cleared by good start", cfg_err, 0);
    prev_tx = tx_level; prev_rx = rx_space;
    while (!finished && cyc < 8000) begin
      cfg_start = 0;
      if (slc_req && cpu_grant) chk(0, "R8 grant during slice", 1, 0);
      if (rej_wait) begin
        chk(start_rej == 1, "R5 reject pulse", start_rej, 1);
        rej_wait = 0;
      end
      if (last_fired) begin
        chk(done == 1, "R9 done pulse", done, 1);
        chk(irq == 1, "R9 irq pulse", irq, 1);
        chk(busy == 0, "R9 busy falls", busy, 0);
        finished = 1;
      end else if (done) chk(0, "R9 early done", 1, 0);
      if (slc_req && !prev_req) begin
        nslc++;
        exp_b = (rem < bpt) ? rem : bpt;
        chk(slc_bytes == exp_b, "R1 R4 slice bytes", slc_bytes, exp_b);
        chk(slc_dir == dir, "R5 slice direction", slc_dir, dir);
        chk(slc_burst == (bpt > 4), "R3 burst flag", slc_burst, bpt > 4);
        chk((dir ? prev_rx : prev_tx) >= slc_bytes, "R6 fifo gate",
            dir ? prev_rx : prev_tx, slc_bytes);
        cnt = $urandom % 4;
        if (do_rej && !rej_sent) begin
          cfg_start = 1; cfg_dir = !dir; cfg_code = 4'd0; cfg_size = SIZE_W'(3);
          rej_sent = 1; rej_wait = 1;
        end
      end
      slc_done = 0;
      if (slc_req) begin
        if (cnt == 0) begin
          slc_done = 1;
          rem -= int'(slc_bytes);
          total += int'(slc_bytes);
          if (rem <= 0) last_fired = 1;
        end else cnt--;
      end
      if (rnd_cpu) begin
        if (!cpu_req) cpu_req = ($urandom % 6 == 0);
        else if (cpu_grant) cpu_req = ($urandom % 3 != 0);
      end
      if (rnd_lvl) begin
        tx_level = 7'($urandom % 72);
        rx_space = 7'($urandom % 72);
      end
      prev_req = slc_req; prev_tx = tx_level; prev_rx = rx_space;
      @(negedge clk);
      cyc++;
    end
    cpu_req = 0; slc_done = 0; cfg_start = 0;
    tx_level = 7'd64; rx_space = 7'd64;
    chk(finished, "R9 packet completes", finished, 1);
    chk(nslc == expn, "R4 slice count", nslc, expn);
    chk(total == size, "R4 byte total", total, size);
    @(negedge clk);
    chk(done == 0, "R9 done lasts one cycle", done, 0);
  endtask

  task automatic starve(input bit dir);
    if (dir) rx_space = 7'd3; else tx_level = 7'd3;
    cfg_start = 1; cfg_code = 4'd2; cfg_dir = dir; cfg_size = SIZE_W'(4);
    @(negedge clk);
    cfg_start = 0;
    for (int i = 0; i < 6; i++) begin
      slc_done = (i % 2 == 0);
      @(negedge clk);
      chk(slc_req == 0, "R6 slice held while fifo short", slc_req, 0);
      chk(busy == 1, "R7 stray slc_done ignored", busy, 1);
    end
    slc_done = 0;
    if (dir) rx_space = 7'd4; else tx_level = 7'd4;
    @(negedge clk);
    chk(slc_req == 1, "R6 slice starts at threshold", slc_req, 1);
    chk(slc_bytes == 4, "R1 slice of code 2", slc_bytes, 4);
    slc_done = 1;
    @(negedge clk);
    slc_done = 0;
    chk(done == 1, "R9 done after single slice", done, 1);
    tx_level = 7'd64; rx_space = 7'd64;
    @(negedge clk);
  endtask

  task automatic cpu_prio();
    cfg_start = 1; cfg_code = 4'd2; cfg_dir = 0; cfg_size = SIZE_W'(8);
    @(negedge clk);
    cfg_start = 0; cpu_req = 1;
    @(negedge clk);
    chk(cpu_grant == 1, "R8 processor first between slices", cpu_grant, 1);
    chk(slc_req == 0, "R8 no slice while granted", slc_req, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(slc_req == 0, "R8 slice waits for release", slc_req, 0);
      chk(cpu_grant == 1, "R8 grant held", cpu_grant, 1);
    end
    cpu_req = 0;
    @(negedge clk);
    chk(cpu_grant == 0, "R8 grant released", cpu_grant, 0);
    @(negedge clk);
    chk(slc_req == 1, "R8 slice after release", slc_req, 1);
    cpu_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cpu_grant == 0, "R8 no grant mid slice", cpu_grant, 0);
      chk(slc_req == 1, "R7 request held until done", slc_req, 1);
    end
    slc_done = 1;
    @(negedge clk);
    slc_done = 0;
    chk(slc_req == 0, "R7 request drops after done", slc_req, 0);
    @(negedge clk);
    chk(cpu_grant == 1, "R8 grant after slice", cpu_grant, 1);
    cpu_req = 0;
    @(negedge clk);
    @(negedge clk);
    chk(slc_req == 1, "R4 second slice issued", slc_req, 1);
    chk(slc_bytes == 4, "R4 second slice bytes", slc_bytes, 4);
    slc_done = 1;
    @(negedge clk);
    slc_done = 0;
    chk(done == 1, "R9 done after two slices", done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(done == 0 && irq == 0, "R10 done/irq after reset", done | irq, 0);
    chk(cfg_err == 0 && start_rej == 0, "R10 flags after reset", cfg_err | start_rej, 0);
    chk(slc_req == 0 && cpu_grant == 0, "R10 bus idle after reset", slc_req | cpu_grant, 0);

    // R2 invalid codes and zero length
    for (int c = 10; c < 16; c++) begin
      cfg_start = 1; cfg_code = 4'(c); cfg_dir = 0; cfg_size = SIZE_W'(10);
      @(negedge clk);
      cfg_start = 0;
      chk(cfg_err == 1, "R2 invalid code flags error", cfg_err, 1);
      chk(busy == 0, "R2 invalid code stays idle", busy, 0);
      @(negedge clk);
      chk(slc_req == 0, "R2 no slice on invalid code", slc_req, 0);
    end
    cfg_start = 1; cfg_code = 4'd1; cfg_size = '0;
    @(negedge clk);
    cfg_start = 0;
    chk(cfg_err == 1 && busy == 0, "R2 zero length rejected", cfg_err, 1);
    @(negedge clk);

    // R1 R3 R4 every valid code, R5 reject on one
    for (int c = 0; c < 10; c++) run_packet(100, c, c % 2, 0, 0, c == 3);

    starve(0);
    starve(1);
    cpu_prio();

    // exact multiples and single-byte packets
    run_packet(56, 9, 1, 0, 0, 1);
    run_packet(1, 9, 0, 0, 0, 0);
    run_packet(48, 5, 0, 0, 0, 0);

    for (int k = 0; k < 40; k++)
      run_packet(1 + $urandom % 200, $urandom % 10, $urandom % 2, 1, 1, ($urandom % 4) == 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule